// File: doc/BRIEF.md
# Pulse Sequence Timing Controller

This block holds a list of timed steps that software loads ahead of time. It plays the list back once a start event arrives. Each step sets a frequency difference, a phase, two amplitude scale factors and a 4-bit control flag word. Bit 0 of the flag word switches the downstream phase-lock loop on, and bit 1 freezes that loop at its present output. Each step stays in force for its programmed number of clock cycles, and then the next stored step takes over. Chirps and shaped pulses are built as staircases of such steps.

Steps are appended through a simple write port. A clear command empties the list, so that a fresh upload does not land behind an old one. A run starts on a one-cycle software pulse or on a rising edge of an asynchronous external trigger. The external trigger passes through a synchronizer and can be masked by a disable input. After the final step has run its time, its values stay on the outputs and a done flag rises.

Top module: `pulse_seq_ctrl`

## Requirements
- R1: After reset all outputs are zero, busy is low and done is low.
- R2: A write stores one step at the next free slot, and steps play in the order they were written. A write is ignored while a run is in progress (busy high or the cycle after an accepted start) or when all DEPTH slots are used.
- R3: A sw_start pulse sampled high at clock edge N, with the list non-empty and the block idle, makes busy rise and step 0 appear on the outputs after edge N+1.
- R4: A step with duration D greater than zero stays on the outputs for exactly D clock cycles, and the next stored step is applied on the following edge.
- R5: A step with duration zero stays on the outputs for exactly one clock cycle.
- R6: At the edge where the last step's time ends, busy falls and done rises. From then on the outputs keep the last step's values until a new start or a clear.
- R7: A rising edge of ext_trig acts as a start. It passes through two synchronizer flops and one edge flop, so if ext_trig rises before edge E0, busy rises after edge E3.
- R8: While ext_trig_dis is high, ext_trig has no effect.
- R9: While done is high, ext_trig has no effect. A sw_start then replays the list from step 0.
- R10: clr, sampled at an edge, empties the list, stops any run, zeroes the outputs and clears done. The next write then goes to slot 0.
- R11: A start with an empty list is ignored, and so is a start while a run is in progress.
- R12: out_flags carries the active step's 4-bit flag field. out_pid_en equals flag bit 0 and out_pid_hold equals flag bit 1.
- R13: busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Empty the list and stop playback |
| wr_en | input | 1 | Append one step |
| wr_freq | input | FREQ_W | Frequency difference of the step |
| wr_phase | input | PHASE_W | Phase of the step |
| wr_amp_a | input | AMP_W | Amplitude factor, channel A |
| wr_amp_b | input | AMP_W | Amplitude factor, channel B |
| wr_dur | input | DUR_W | Hold time in clock cycles (0 means 1) |
| wr_flags | input | FLAG_W | Control flags of the step |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| ext_trig_dis | input | 1 | Mask for ext_trig |
| out_freq | output | FREQ_W | Active frequency difference |
| out_phase | output | PHASE_W | Active phase |
| out_amp_a | output | AMP_W | Active amplitude A |
| out_amp_b | output | AMP_W | Active amplitude B |
| out_flags | output | FLAG_W | Active flag word |
| out_pid_en | output | 1 | Loop enable (flag bit 0) |
| out_pid_hold | output | 1 | Loop hold (flag bit 1) |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Last step finished |

## Verification
The list is played with mixed durations, including zero and one, so that a one-cycle slip in hold counting stands out from a correct step change. The same list is then replayed after a start that arrives mid-run and after a write that arrives mid-run, which separates ignored stimuli from stimuli that were wrongly accepted. The external trigger is driven while it is masked, while done is high and while it is enabled, and in each case the cycle where busy rises is checked, so that the synchronizer latency is pinned down. A list that overflows the slots, a clear in the middle of a run and a start on an empty list exercise the boundaries of the pointer and of the state machine.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_PRIME = 2'd1,
      PS_RUN   = 2'd2
   } ps_state_e;

endpackage

// File: rtl/pulse_seq_store.sv
module pulse_seq_store #(
   parameter int DEPTH  = 1024,
   parameter int WORD_W = 116,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic              wr_allow,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata,
   output logic [AW:0]       count
);

   localparam logic [AW:0] SLOTS = (AW+1)'(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW:0]       wr_ptr;
   logic              do_wr;

   assign do_wr = wr_en && wr_allow && !clr && (wr_ptr < SLOTS);
   assign count = wr_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n)     wr_ptr <= '0;
      else if (clr)   wr_ptr <= '0;
      else if (do_wr) wr_ptr <= wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_word;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/pulse_seq_trig.sv
module pulse_seq_trig #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pulse_seq_trig: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/pulse_seq_player.sv
module pulse_seq_player
   import pulse_seq_pkg::*;
#(
   parameter int DEPTH   = 1024,
   parameter int FREQ_W  = 32,
   parameter int PHASE_W = 16,
   parameter int AMP_W   = 16,
   parameter int DUR_W   = 32,
   parameter int FLAG_W  = 4,
   localparam int AW     = $clog2(DEPTH),
   localparam int WORD_W = FREQ_W + PHASE_W + 2*AMP_W + DUR_W + FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start_req,
   input  logic [AW:0]       count,
   input  logic [WORD_W-1:0] rdata,
   output logic [AW-1:0]     raddr,
   output logic              idle,
   output logic [WORD_W-1:0] cur,
   output logic              busy,
   output logic              done
);

   localparam int DUR_LO = FLAG_W;

   ps_state_e        state;
   logic [AW:0]      idx;
   logic [DUR_W-1:0] timer;
   logic [AW:0]      nxt;
   logic [DUR_W-1:0] dur_in;
   logic [DUR_W-1:0] load_val;

   assign dur_in   = rdata[DUR_LO +: DUR_W];
   assign load_val = (dur_in == '0) ? '0 : dur_in - 1'b1;

   always_comb begin
      unique case (state)
         PS_PRIME: nxt = (AW+1)'(1);
         PS_RUN:   nxt = (timer == '0) ? idx + 1'b1 : idx;
         default:  nxt = '0;
      endcase
   end

   assign raddr = nxt[AW-1:0];
   assign idle  = (state == PS_IDLE);
   assign busy  = (state == PS_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         state <= PS_IDLE;
         idx   <= '0;
         timer <= '0;
         cur   <= '0;
         done  <= 1'b0;
      end else begin
         unique case (state)
            PS_IDLE: begin
               if (start_req && count != '0) begin
                  state <= PS_PRIME;
                  done  <= 1'b0;
               end
            end
            PS_PRIME: begin
               cur   <= rdata;
               timer <= load_val;
               idx   <= (AW+1)'(1);
               state <= PS_RUN;
            end
            PS_RUN: begin
               if (timer != '0) begin
                  timer <= timer - 1'b1;
               end else if (idx == count) begin
                  state <= PS_IDLE;
                  done  <= 1'b1;
               end else begin
                  cur   <= rdata;
                  timer <= load_val;
                  idx   <= idx + 1'b1;
               end
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl #(
   parameter int DEPTH       = 1024,
   parameter int FREQ_W      = 32,
   parameter int PHASE_W     = 16,
   parameter int AMP_W       = 16,
   parameter int DUR_W       = 32,
   parameter int FLAG_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_en,
   input  logic [FREQ_W-1:0]  wr_freq,
   input  logic [PHASE_W-1:0] wr_phase,
   input  logic [AMP_W-1:0]   wr_amp_a,
   input  logic [AMP_W-1:0]   wr_amp_b,
   input  logic [DUR_W-1:0]   wr_dur,
   input  logic [FLAG_W-1:0]  wr_flags,
   input  logic               sw_start,
   input  logic               ext_trig,
   input  logic               ext_trig_dis,
   output logic [FREQ_W-1:0]  out_freq,
   output logic [PHASE_W-1:0] out_phase,
   output logic [AMP_W-1:0]   out_amp_a,
   output logic [AMP_W-1:0]   out_amp_b,
   output logic [FLAG_W-1:0]  out_flags,
   output logic               out_pid_en,
   output logic               out_pid_hold,
   output logic               busy,
   output logic               done
);

   localparam int AW     = $clog2(DEPTH);
   localparam int WORD_W = FREQ_W + PHASE_W + 2*AMP_W + DUR_W + FLAG_W;
   localparam int O_DUR  = FLAG_W;
   localparam int O_AMPB = O_DUR + DUR_W;
   localparam int O_AMPA = O_AMPB + AMP_W;
   localparam int O_PH   = O_AMPA + AMP_W;
   localparam int O_FRQ  = O_PH + PHASE_W;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pulse_seq_ctrl: DEPTH must be a power of two, at least 2");
      end
      if (FLAG_W < 2) begin : g_bad_flags
         $error("pulse_seq_ctrl: FLAG_W must hold the enable and hold bits");
      end
      if (DUR_W < 1 || FREQ_W < 1 || PHASE_W < 1 || AMP_W < 1) begin : g_bad_w
         $error("pulse_seq_ctrl: field widths must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] rdata;
   logic [WORD_W-1:0] cur;
   logic [AW-1:0]     raddr;
   logic [AW:0]       count;
   logic              idle;
   logic              trig_rise;
   logic              start_req;

   assign wr_word   = {wr_freq, wr_phase, wr_amp_a, wr_amp_b, wr_dur, wr_flags};
   assign start_req = sw_start | (trig_rise & ~ext_trig_dis & ~done);

   pulse_seq_store #(
      .DEPTH  (DEPTH),
      .WORD_W (WORD_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .wr_en    (wr_en),
      .wr_allow (idle),
      .wr_word  (wr_word),
      .raddr    (raddr),
      .rdata    (rdata),
      .count    (count)
   );

   pulse_seq_trig #(
      .STAGES (SYNC_STAGES)
   ) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_trig),
      .rise  (trig_rise)
   );

   pulse_seq_player #(
      .DEPTH   (DEPTH),
      .FREQ_W  (FREQ_W),
      .PHASE_W (PHASE_W),
      .AMP_W   (AMP_W),
      .DUR_W   (DUR_W),
      .FLAG_W  (FLAG_W)
   ) u_player (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .start_req (start_req),
      .count     (count),
      .rdata     (rdata),
      .raddr     (raddr),
      .idle      (idle),
      .cur       (cur),
      .busy      (busy),
      .done      (done)
   );

   assign out_freq     = cur[O_FRQ  +: FREQ_W];
   assign out_phase    = cur[O_PH   +: PHASE_W];
   assign out_amp_a    = cur[O_AMPA +: AMP_W];
   assign out_amp_b    = cur[O_AMPB +: AMP_W];
   assign out_flags    = cur[0 +: FLAG_W];
   assign out_pid_en   = cur[0];
   assign out_pid_hold = cur[1];

endmodule

// File: rtl/pulse_seq_ctrl_chk.sv
module pulse_seq_ctrl_chk #(
   parameter int FREQ_W = 32,
   parameter int FLAG_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              sw_start,
   input logic              busy,
   input logic              done,
   input logic [FREQ_W-1:0] out_freq,
   input logic [FLAG_W-1:0] out_flags
);

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R13

   AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!busy && !done && out_freq == '0)); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && !$past(clr)) |-> ($stable(out_freq) && $stable(out_flags))); // R6

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr && !sw_start) |=> done); // R9

endmodule

bind pulse_seq_ctrl pulse_seq_ctrl_chk #(
   .FREQ_W (FREQ_W),
   .FLAG_W (FLAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .sw_start  (sw_start),
   .busy      (busy),
   .done      (done),
   .out_freq  (out_freq),
   .out_flags (out_flags)
);

// File: tb/pulse_seq_ctrl_tb.sv
module pulse_seq_ctrl_tb;

   localparam int DEPTH = 8;

   typedef struct {
      logic [31:0] f;
      logic [15:0] p;
      logic [15:0] a;
      logic [15:0] b;
      logic [31:0] d;
      logic [3:0]  fl;
   } step_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_freq = '0;
   logic [15:0] wr_phase = '0;
   logic [15:0] wr_amp_a = '0;
   logic [15:0] wr_amp_b = '0;
   logic [31:0] wr_dur = '0;
   logic [3:0]  wr_flags = '0;
   logic        sw_start = 1'b0;
   logic        ext_trig = 1'b0;
   logic        ext_trig_dis = 1'b0;
   logic [31:0] out_freq;
   logic [15:0] out_phase;
   logic [15:0] out_amp_a;
   logic [15:0] out_amp_b;
   logic [3:0]  out_flags;
   logic        out_pid_en;
   logic        out_pid_hold;
   logic        busy;
   logic        done;

   int n_tests = 0;
   int n_fail  = 0;

   step_t model[$];
   step_t exp_q[$];

   always #10 clk = ~clk;

   pulse_seq_ctrl #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
      .wr_freq(wr_freq), .wr_phase(wr_phase), .wr_amp_a(wr_amp_a),
      .wr_amp_b(wr_amp_b), .wr_dur(wr_dur), .wr_flags(wr_flags),
      .sw_start(sw_start), .ext_trig(ext_trig), .ext_trig_dis(ext_trig_dis),
      .out_freq(out_freq), .out_phase(out_phase), .out_amp_a(out_amp_a),
      .out_amp_b(out_amp_b), .out_flags(out_flags), .out_pid_en(out_pid_en),
      .out_pid_hold(out_pid_hold), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor / scoreboard
   bit    mon_en = 1'b1;
   bit    prev_busy = 1'b0;
   bit    have = 1'b0;
   int    hold = 0;
   step_t cur_exp;
   logic [99:0] prev_vec = '0;
   logic [99:0] vec;

   task automatic close_item();
      int want;
      want = (cur_exp.d == 0) ? 1 : int'(cur_exp.d);
      chk(hold == want, (cur_exp.d == 0) ? "R5 zero-duration hold" : "R4 hold length",
          hold, want);
   endtask

   always @(negedge clk) begin
      vec = {out_freq, out_phase, out_amp_a, out_amp_b, out_flags};
      if (!mon_en) begin
         prev_busy = 1'b0;
         have = 1'b0;
      end else begin
         if (busy && (!prev_busy || vec != prev_vec)) begin
            if (have) close_item();
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected step", out_freq, 0);
               have = 1'b0;
            end else begin
               cur_exp = exp_q.pop_front();
               chk(out_freq == cur_exp.f, "R4 order freq", out_freq, cur_exp.f);
               chk({out_phase, out_amp_a, out_amp_b} == {cur_exp.p, cur_exp.a, cur_exp.b},
                   "R4 fields", {out_phase, out_amp_a, out_amp_b}, {cur_exp.p, cur_exp.a, cur_exp.b});
               chk(out_flags == cur_exp.fl && out_pid_en == cur_exp.fl[0] &&
                   out_pid_hold == cur_exp.fl[1], "R12 flags", out_flags, cur_exp.fl);
               hold = 1;
               have = 1'b1;
            end
         end else if (busy) begin
            hold++;
         end
         if (!busy && prev_busy && have) begin
            close_item();
            have = 1'b0;
         end
         prev_busy = busy;
         prev_vec  = vec;
      end
   end

   task automatic put(input logic [31:0] f, input logic [31:0] d, input logic [3:0] fl,
                      input bit expect_ok);
      step_t s;
      s.f = f; s.p = f[15:0] ^ 16'h5a5a; s.a = f[15:0] + 16'd7; s.b = ~f[15:0];
      s.d = d; s.fl = fl;
      @(negedge clk);
      wr_en = 1'b1; wr_freq = s.f; wr_phase = s.p; wr_amp_a = s.a;
      wr_amp_b = s.b; wr_dur = s.d; wr_flags = s.fl;
      @(negedge clk);
      wr_en = 1'b0;
      if (expect_ok) model.push_back(s);
   endtask

   task automatic arm();
      foreach (model[i]) exp_q.push_back(model[i]);
   endtask

   task automatic pulse_start();
      @(negedge clk); sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      model.delete();
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 2000) begin @(negedge clk); t++; end
      chk(done == 1'b1 && busy == 1'b0, "R6 done after last", done, 1);
      chk(out_freq == model[model.size()-1].f, "R6 last values kept", out_freq,
          model[model.size()-1].f);
      repeat (3) @(negedge clk);
      chk(out_freq == model[model.size()-1].f && done, "R6 outputs held", out_freq,
          model[model.size()-1].f);
      chk(exp_q.size() == 0, "R2 all steps played", exp_q.size(), 0);
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(out_freq == 0 && out_flags == 0 && out_amp_a == 0 && !busy && !done,
          "R1 reset state", {busy, done, out_freq}, 0);

      // R11 empty list start ignored
      pulse_start();
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R11 empty start ignored", busy, 0);

      // main list with varied durations
      put(32'h100, 3, 4'b0001, 1);
      put(32'h200, 0, 4'b0011, 1);
      put(32'h300, 5, 4'b0000, 1);
      put(32'h400, 1, 4'b0010, 1);
      put(32'h500, 2, 4'b1001, 1);
      arm();
      // R3 latency
      @(negedge clk); sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
      chk(!busy && out_freq == 0, "R3 no output after start edge", busy, 0);
      @(negedge clk);
      chk(busy && out_freq == 32'h100, "R3 step 0 one edge later", out_freq, 32'h100);
      // R11 start while busy, R2 write while busy ignored
      pulse_start();
      put(32'h999, 4, 4'b0001, 0);
      wait_done();

      // R9 ext trig ignored while done
      @(negedge clk); ext_trig = 1'b1;
      repeat (4) @(negedge clk); ext_trig = 1'b0;
      repeat (6) @(negedge clk);
      chk(!busy && done, "R9 ext trig ignored when done", busy, 0);
      // R9 software replay
      arm();
      pulse_start();
      wait_done();

      // R10 clear while idle
      pulse_clr();
      chk(!busy && !done && out_freq == 0, "R10 clear state", out_freq, 0);
      pulse_start();
      repeat (3) @(negedge clk);
      chk(!busy, "R10 list emptied", busy, 0);

      // R8 masked trigger
      put(32'hA00, 2, 4'b0001, 1);
      put(32'hB00, 0, 4'b0010, 1);
      ext_trig_dis = 1'b1;
      @(negedge clk); ext_trig = 1'b1;
      repeat (8) @(negedge clk);
      chk(!busy, "R8 masked trigger", busy, 0);
      ext_trig = 1'b0;
      repeat (4) @(negedge clk);
      ext_trig_dis = 1'b0;
      // R7 latency
      arm();
      ext_trig = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk(!busy, "R7 not yet started after E2", busy, 0);
      @(negedge clk);
      chk(busy && out_freq == 32'hA00, "R7 started after E3", busy, 1);
      ext_trig = 1'b0;
      wait_done();

      // R2 full list: 9 writes, 8 kept
      pulse_clr();
      for (int k = 0; k < DEPTH + 1; k++) put(32'h1000 + k, k % 3, 4'(k), k < DEPTH);
      arm();
      pulse_start();
      wait_done();

      // R10 clear during a run, then write goes to slot 0
      mon_en = 1'b0;
      pulse_start();
      repeat (3) @(negedge clk);
      chk(busy, "R10 run in progress", busy, 1);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      model.delete();
      chk(!busy && !done && out_freq == 0, "R10 clear mid-run", out_freq, 0);
      @(negedge clk);
      mon_en = 1'b1;
      put(32'hC00, 1, 4'b0011, 1);
      arm();
      pulse_start();
      wait_done();

      repeat (4) @(negedge clk);
      report();
   end

endmodule